// File: doc/BRIEF.md
# Inclusive L2 Back-Invalidation Filter

This block is the coherence bookkeeping that sits beside an inclusive second-level cache, where only the L2 is visible to bus snooping. For every L2 line it holds two flags. The first says the line may also live in the private L1. The second says the L1 copy has been written and L2's own data is out of date. The L1 is direct-mapped and uses the L2 line size, and its controller reports three kinds of event by L2 line index: fills, write hits and its own evictions.

Two kinds of event force the L1 copy out. One is an L2 replacement, arriving on the victim port. The other is an observed bus read-exclusive to a line that L2 holds, arriving on the snoop port. For each one the block checks the inclusion flag. If the flag is clear, the request finishes at once and no L1 traffic is generated. If the flag is set, the block issues one back-invalidate to the L1, with a flush qualifier when the stale flag is set, and holds it until the L1 acknowledges. Only then does it report completion. The L2 controller must not change that line's state before completion. When completion carries the dirty indication, the flushed L1 data is the copy that L2 must use.

Top module: `l2_incl_guard`

## Requirements
- R1: After reset every line has both flags clear, `binv_vld` and `done_vld` are 0, and both request readies are 1.
- R2: An L1 fill notification for index i sets that line's inclusion flag, so a later victim or snoop request for i drives `binv_vld`=1 with `binv_idx`=i exactly one cycle after the request is accepted.
- R3: A request for a line whose inclusion flag is clear never raises `binv_vld`. It completes with `done_vld`=1 one cycle after acceptance and `done_dirty`=0.
- R4: `binv_flush` is 1 exactly when the line's stale flag is set. `done_dirty` for that request equals the flush value that was issued.
- R5: While `binv_vld` is 1 and `binv_ack` is 0, the next cycle keeps `binv_vld`=1 with unchanged `binv_idx` and `binv_flush`, and `done_vld` stays 0.
- R6: The cycle after `binv_vld` and `binv_ack` are both 1, `binv_vld` is 0 and `done_vld` is 1 for exactly one cycle. `done_idx` carries the request index and `done_snoop` carries its source (1 = snoop, 0 = victim).
- R7: A completed back-invalidate clears both flags of that line, so a repeated request for the same index is filtered as in R3.
- R8: An L1 eviction notification clears both flags of its line.
- R9: When a snoop and a victim request are both valid in an idle cycle, the snoop is accepted (`snp_rdy`=1, `vic_rdy`=0) and completes with `done_snoop`=1.
- R10: From acceptance until the completion cycle ends, `snp_rdy` and `vic_rdy` are 0, and `binv_ack` outside a pending back-invalidate has no effect.
- R11: An L1 write-hit notification sets the stale flag only when the line's inclusion flag is already set. A write hit to a non-included line is ignored, so a later fill followed by a request gives `binv_flush`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_fill_vld | input | 1 | L1 has filled a line |
| l1_fill_idx | input | IDX_W | L2 line index of the fill |
| l1_wrhit_vld | input | 1 | L1 write hit |
| l1_wrhit_idx | input | IDX_W | L2 line index of the write hit |
| l1_evict_vld | input | 1 | L1 has dropped a line (dirty data already returned) |
| l1_evict_idx | input | IDX_W | L2 line index of the L1 eviction |
| snp_vld | input | 1 | Bus read-exclusive observed to a line held in L2 |
| snp_idx | input | IDX_W | Line index of the snoop |
| snp_rdy | output | 1 | Snoop request accepted this cycle if valid |
| vic_vld | input | 1 | L2 is replacing a line |
| vic_idx | input | IDX_W | Line index of the victim |
| vic_rdy | output | 1 | Victim request accepted this cycle if valid |
| binv_vld | output | 1 | Back-invalidate request to L1 |
| binv_idx | output | IDX_W | Line index to invalidate in L1 |
| binv_flush | output | 1 | L1 must return its modified data with the invalidate |
| binv_ack | input | 1 | L1 acknowledges the back-invalidate |
| done_vld | output | 1 | Request finished; L2 may change the line |
| done_snoop | output | 1 | Finished request came from the snoop port |
| done_idx | output | IDX_W | Line index of the finished request |
| done_dirty | output | 1 | Modified data was pulled from L1 for this request |

## Verification
The checks assume that the L1 raises `binv_ack` only in a cycle where `binv_vld` is high, and that a requester holds its valid until it sees ready. They also assume that notifications for a line never arrive while a back-invalidate for that same line is pending. The stimulus drives every request for a single cycle, sampled while the block is idle. The acknowledge goes high only after `binv_vld` has been seen, and one separate step pulses it during idle to show that it is ignored. Fills, write hits and L1 evictions are all issued between requests, so no notification can reach a line in the middle of its handshake.

// File: rtl/l2ig_pkg.sv
package l2ig_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BINV = 2'd1,
      ST_DONE = 2'd2
   } l2ig_state_e;

   localparam logic SRC_VICTIM = 1'b0;
   localparam logic SRC_SNOOP  = 1'b1;
endpackage

// File: rtl/l2ig_line_bits.sv
module l2ig_line_bits #(
   parameter int LINES = 16,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_vld,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic             wrhit_vld,
   input  logic [IDX_W-1:0] wrhit_idx,
   input  logic             evict_vld,
   input  logic [IDX_W-1:0] evict_idx,
   input  logic             clr_vld,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             incl_o,
   output logic             stale_o
);
   logic [LINES-1:0] incl_q;
   logic [LINES-1:0] stale_q;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic hit_fill, hit_wr, hit_drop;
      assign hit_fill = fill_vld  && (fill_idx  == IDX_W'(g));
      assign hit_wr   = wrhit_vld && (wrhit_idx == IDX_W'(g));
      assign hit_drop = (evict_vld && (evict_idx == IDX_W'(g))) ||
                        (clr_vld   && (clr_idx   == IDX_W'(g)));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            incl_q[g]  <= 1'b0;
            stale_q[g] <= 1'b0;
         end else if (hit_drop) begin
            incl_q[g]  <= 1'b0;
            stale_q[g] <= 1'b0;
         end else begin
            if (hit_fill) incl_q[g] <= 1'b1;
            if (hit_wr && incl_q[g]) stale_q[g] <= 1'b1;
         end
      end
   end

   assign incl_o  = incl_q[rd_idx];
   assign stale_o = stale_q[rd_idx];
endmodule

// File: rtl/l2ig_arb.sv
module l2ig_arb #(
   parameter bit SNOOP_FIRST = 1'b1
) (
   input  logic idle,
   input  logic snp_vld,
   input  logic vic_vld,
   output logic snp_rdy,
   output logic vic_rdy,
   output logic take_snp
);
   if (SNOOP_FIRST) begin : g_snp_first
      assign snp_rdy = idle;
      assign vic_rdy = idle && !snp_vld;
   end else begin : g_vic_first
      assign vic_rdy = idle;
      assign snp_rdy = idle && !vic_vld;
   end

   assign take_snp = snp_vld && snp_rdy;
endmodule

// File: rtl/l2ig_ctrl.sv
module l2ig_ctrl
   import l2ig_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             acc_snp,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             incl_hit,
   input  logic             stale_hit,
   input  logic             binv_ack,
   output logic             idle,
   output logic             binv_vld,
   output logic [IDX_W-1:0] binv_idx,
   output logic             binv_flush,
   output logic             done_vld,
   output logic             done_snoop,
   output logic [IDX_W-1:0] done_idx,
   output logic             done_dirty,
   output logic             clr_vld,
   output logic [IDX_W-1:0] clr_idx
);
   l2ig_state_e      state_q;
   logic [IDX_W-1:0] idx_q;
   logic             snp_q;
   logic             flush_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         snp_q   <= SRC_VICTIM;
         flush_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               idx_q   <= acc_idx;
               snp_q   <= acc_snp;
               flush_q <= incl_hit && stale_hit;
               state_q <= incl_hit ? ST_BINV : ST_DONE;
            end
            ST_BINV: if (binv_ack) state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle       = (state_q == ST_IDLE);
   assign binv_vld   = (state_q == ST_BINV);
   assign binv_idx   = idx_q;
   assign binv_flush = flush_q;
   assign done_vld   = (state_q == ST_DONE);
   assign done_snoop = snp_q;
   assign done_idx   = idx_q;
   assign done_dirty = flush_q;
   assign clr_vld    = binv_vld && binv_ack;
   assign clr_idx    = idx_q;
endmodule

// File: rtl/l2_incl_guard.sv
module l2_incl_guard #(
   parameter int L2_LINES    = 16,
   parameter bit SNOOP_FIRST = 1'b1,
   localparam int IDX_W      = $clog2(L2_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l1_fill_vld,
   input  logic [IDX_W-1:0] l1_fill_idx,
   input  logic             l1_wrhit_vld,
   input  logic [IDX_W-1:0] l1_wrhit_idx,
   input  logic             l1_evict_vld,
   input  logic [IDX_W-1:0] l1_evict_idx,
   input  logic             snp_vld,
   input  logic [IDX_W-1:0] snp_idx,
   output logic             snp_rdy,
   input  logic             vic_vld,
   input  logic [IDX_W-1:0] vic_idx,
   output logic             vic_rdy,
   output logic             binv_vld,
   output logic [IDX_W-1:0] binv_idx,
   output logic             binv_flush,
   input  logic             binv_ack,
   output logic             done_vld,
   output logic             done_snoop,
   output logic [IDX_W-1:0] done_idx,
   output logic             done_dirty
);
   if (L2_LINES < 2 || (L2_LINES & (L2_LINES - 1)) != 0) begin : g_bad_lines
      initial $fatal(1, "L2_LINES must be a power of two, at least 2");
   end

   logic             idle, take_snp, accept;
   logic [IDX_W-1:0] acc_idx;
   logic             incl_hit, stale_hit;
   logic             clr_vld;
   logic [IDX_W-1:0] clr_idx;

   l2ig_arb #(.SNOOP_FIRST(SNOOP_FIRST)) u_arb (
      .idle     (idle),
      .snp_vld  (snp_vld),
      .vic_vld  (vic_vld),
      .snp_rdy  (snp_rdy),
      .vic_rdy  (vic_rdy),
      .take_snp (take_snp)
   );

   assign accept  = take_snp || (vic_vld && vic_rdy);
   assign acc_idx = take_snp ? snp_idx : vic_idx;

   l2ig_line_bits #(.LINES(L2_LINES), .IDX_W(IDX_W)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_vld  (l1_fill_vld),
      .fill_idx  (l1_fill_idx),
      .wrhit_vld (l1_wrhit_vld),
      .wrhit_idx (l1_wrhit_idx),
      .evict_vld (l1_evict_vld),
      .evict_idx (l1_evict_idx),
      .clr_vld   (clr_vld),
      .clr_idx   (clr_idx),
      .rd_idx    (acc_idx),
      .incl_o    (incl_hit),
      .stale_o   (stale_hit)
   );

   l2ig_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .acc_snp    (take_snp),
      .acc_idx    (acc_idx),
      .incl_hit   (incl_hit),
      .stale_hit  (stale_hit),
      .binv_ack   (binv_ack),
      .idle       (idle),
      .binv_vld   (binv_vld),
      .binv_idx   (binv_idx),
      .binv_flush (binv_flush),
      .done_vld   (done_vld),
      .done_snoop (done_snoop),
      .done_idx   (done_idx),
      .done_dirty (done_dirty),
      .clr_vld    (clr_vld),
      .clr_idx    (clr_idx)
   );
endmodule

// File: rtl/l2ig_checker.sv
module l2ig_checker #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snp_vld,
   input logic             snp_rdy,
   input logic             vic_vld,
   input logic             vic_rdy,
   input logic             binv_vld,
   input logic [IDX_W-1:0] binv_idx,
   input logic             binv_flush,
   input logic             binv_ack,
   input logic             done_vld
);
   // R5: a pending back-invalidate holds still until acknowledged
   a_r5_binv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      binv_vld && !binv_ack |=> binv_vld && $stable(binv_idx) && $stable(binv_flush) && !done_vld);

   // R6: acknowledge leads to completion in the next cycle
   a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      binv_vld && binv_ack |=> done_vld && !binv_vld);

   // R6: completion lasts a single cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |=> !done_vld);

   // R10: no request is taken while busy
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      binv_vld || done_vld |-> !snp_rdy && !vic_rdy);

   // R2, R3: an accepted request moves on in the following cycle
   a_r3_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_vld && snp_rdy) || (vic_vld && vic_rdy) |=> done_vld || binv_vld);

   // R9: only one port is granted when both ask
   a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      snp_vld && vic_vld |-> !(snp_rdy && vic_rdy));
endmodule

bind l2_incl_guard l2ig_checker #(.IDX_W(IDX_W)) u_l2ig_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .snp_vld    (snp_vld),
   .snp_rdy    (snp_rdy),
   .vic_vld    (vic_vld),
   .vic_rdy    (vic_rdy),
   .binv_vld   (binv_vld),
   .binv_idx   (binv_idx),
   .binv_flush (binv_flush),
   .binv_ack   (binv_ack),
   .done_vld   (done_vld)
);

// File: tb/tb_l2_incl_guard.sv
module tb_l2_incl_guard;
   localparam int LINES  = 8;
   localparam int IW     = 3;
   localparam int CLK_PD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          l1_fill_vld = 0, l1_wrhit_vld = 0, l1_evict_vld = 0;
   logic [IW-1:0] l1_fill_idx = '0, l1_wrhit_idx = '0, l1_evict_idx = '0;
   logic          snp_vld = 0, vic_vld = 0, binv_ack = 0;
   logic [IW-1:0] snp_idx = '0, vic_idx = '0;
   logic          snp_rdy, vic_rdy, binv_vld, binv_flush;
   logic          done_vld, done_snoop, done_dirty;
   logic [IW-1:0] binv_idx, done_idx;

   int n_chk = 0;
   int n_err = 0;
   bit m_incl [LINES];
   bit m_stale[LINES];

   always #(CLK_PD/2) clk = ~clk;

   l2_incl_guard #(.L2_LINES(LINES), .SNOOP_FIRST(1'b1)) dut (.*);

   task automatic chk(input int act, input int exp, input string rq, input string what);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic notify(input int kind, input int idx);
      @(negedge clk);
      case (kind)
         0: begin l1_fill_vld = 1; l1_fill_idx = IW'(idx); m_incl[idx] = 1; end
         1: begin l1_wrhit_vld = 1; l1_wrhit_idx = IW'(idx); if (m_incl[idx]) m_stale[idx] = 1; end
         default: begin l1_evict_vld = 1; l1_evict_idx = IW'(idx); m_incl[idx] = 0; m_stale[idx] = 0; end
      endcase
      @(negedge clk);
      l1_fill_vld = 0; l1_wrhit_vld = 0; l1_evict_vld = 0;
   endtask

   task automatic run_req(input bit snp, input int idx, input int ack_wait, input string rq);
      bit eb = m_incl[idx];
      bit ef = m_stale[idx] && m_incl[idx];
      @(negedge clk);
      if (snp) begin snp_vld = 1; snp_idx = IW'(idx); end
      else begin vic_vld = 1; vic_idx = IW'(idx); end
      #1;
      chk(snp ? int'(snp_rdy) : int'(vic_rdy), 1, "R10", "ready when idle");
      @(negedge clk);
      snp_vld = 0; vic_vld = 0;
      if (eb) begin
         chk(binv_vld, 1, rq, "binv_vld raised");
         chk(binv_idx, idx, "R2", "binv_idx");
         chk(binv_flush, ef, "R4", "binv_flush");
         chk(snp_rdy, 0, "R10", "snp_rdy while busy");
         for (int w = 0; w < ack_wait; w++) begin
            @(negedge clk);
            chk(binv_vld, 1, "R5", "binv_vld held");
            chk(binv_idx, idx, "R5", "binv_idx held");
            chk(done_vld, 0, "R5", "no done before ack");
         end
         binv_ack = 1;
         @(negedge clk);
         binv_ack = 0;
         chk(binv_vld, 0, "R6", "binv_vld dropped");
      end else begin
         chk(binv_vld, 0, rq, "filtered request has no binv");
      end
      chk(done_vld, 1, "R6", "done_vld");
      chk(done_idx, idx, "R6", "done_idx");
      chk(done_snoop, snp, "R6", "done_snoop");
      chk(done_dirty, ef, eb ? "R4" : "R3", "done_dirty");
      m_incl[idx] = 0;
      m_stale[idx] = 0;
      @(negedge clk);
      chk(done_vld, 0, "R6", "done single cycle");
      chk(vic_rdy, 1, "R10", "ready after done");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(binv_vld, 0, "R1", "binv_vld after reset");
      chk(done_vld, 0, "R1", "done_vld after reset");
      chk(snp_rdy, 1, "R1", "snp_rdy after reset");
      chk(vic_rdy, 1, "R1", "vic_rdy after reset");
      for (int i = 0; i < LINES; i++) run_req(i[0], i, 0, "R1");

      for (int i = 0; i < LINES; i++) begin
         run_req(1'b0, i, 0, "R3");
         notify(0, i);
         run_req(1'b0, i, i % 3, "R2");
         run_req(1'b1, i, 0, "R7");
         notify(0, i);
         notify(1, i);
         run_req(1'b1, i, (i + 1) % 3, "R4");
         notify(1, i);
         notify(0, (i + 3) % LINES);
         notify(0, i);
         run_req(1'b0, i, 1, "R11");
         notify(0, i);
         notify(1, i);
         notify(2, i);
         run_req(1'b1, i, 0, "R8");
      end
      for (int i = 0; i < LINES; i++) if (m_incl[i]) run_req(1'b0, i, 0, "R2");

      // R9: simultaneous snoop and victim
      notify(0, 5);
      @(negedge clk);
      snp_vld = 1; snp_idx = 3'd2; vic_vld = 1; vic_idx = 3'd5;
      #1;
      chk(snp_rdy, 1, "R9", "snp_rdy with both valid");
      chk(vic_rdy, 0, "R9", "vic_rdy with both valid");
      @(negedge clk);
      snp_vld = 0; vic_vld = 0;
      chk(done_vld, 1, "R9", "snoop finished first");
      chk(done_snoop, 1, "R9", "done_snoop");
      chk(done_idx, 2, "R9", "done_idx");
      @(negedge clk);
      run_req(1'b0, 5, 2, "R9");

      // R10: acknowledge while idle is ignored
      @(negedge clk);
      binv_ack = 1;
      @(negedge clk);
      binv_ack = 0;
      chk(binv_vld, 0, "R10", "binv_vld after idle ack");
      chk(done_vld, 0, "R10", "done_vld after idle ack");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule